// File: doc/BRIEF.md
# SPI Channel Word Engine

This block is one channel of a multichannel SPI master. It holds the channel's configuration word, its enable bit, a three-flag status word and the transmit and receive data registers, all reached through a small strobe-based register port. When software writes transmit data, reads received data or turns the channel on, the block asks for a transfer. One cycle later it decides whether a word may start. That decision depends on the enable bit, the transfer mode, the turbo bit and the current flags.

A started word is exchanged by a built-in shifter, most significant bit first. The shifter gives one SPI bit every two clock cycles: the clock is low for the first cycle and high for the second, and the input line is sampled when the high cycle ends. In single-channel module mode, a word is only exchanged if the channel's force bit is set. Otherwise the transfer completes at once without clocking, and only the flags change. The block drives level DMA requests for transmit and receive. It also drives one-cycle transmit-empty and receive-full event pulses toward an interrupt aggregator.

Top module: `spi_chan_engine`

## Requirements
- R1: Register select encoding: 0 = configuration, 1 = status, 2 = control, 3 = transmit data, 4 = receive data. Configuration writes keep bits 22:0 and read back with bits 31:23 as zero. Reset leaves configuration 0x060000, status 2, control 0 and both data registers 0. Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-transfer.
- R2: The word length is configuration bits 11:7 plus one, from 1 to 32. Bits go out MSB first. Each bit takes two cycles, with SCLK high only in the second cycle. MISO is sampled at the end of the high cycle, and the received word is right-aligned.
- R3: Configuration bits 13:12 select the mode: 0 full duplex, 1 receive only, 2 transmit only, 3 treated like full duplex for gating.
- R4: A word may start only if all of these hold: the channel is enabled; receive-full is not blocking, which it does when set unless the mode is transmit only or turbo (bit 19) is set; transmit-empty is not blocking, which it does when set unless the mode is receive only.
- R5: Bits are clocked only when the single-channel input is low or force (bit 20) is set. Otherwise an allowed start completes on the deciding edge without any SCLK pulse, and the receive register is unchanged.
- R6: Completion clears the transmit register and sets end-of-transfer and transmit-empty. It also sets receive-full unless the mode is transmit only. After a clocked word, these flags are visible in the cycle after the last high SCLK cycle.
- R7: The transmit DMA request is enable AND bit 14 AND transmit-empty AND mode not receive only. The receive DMA request is enable AND bit 15 AND receive-full AND mode not transmit only.
- R8: For one cycle after each completed or blocked start decision on an enabled channel, the transmit-empty event is high if transmit-empty is set and the mode is not receive only. The receive-full event is high if receive-full is set, the mode is not transmit only and turbo is clear.
- R9: Three things request a start decision: a transmit-data write, which also clears transmit-empty; a receive-data read, which also clears receive-full; and a control write that sets the enable bit from zero. The decision is taken one cycle after the request, or when the shifter goes idle if it is busy.
- R10: With the channel disabled, a request starts nothing and raises no event. End-of-transfer stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| single_chan | input | 1 | Module single-channel mode |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| rx_full | output | 1 | Receive-full flag |
| tx_empty | output | 1 | Transmit-empty flag |
| end_of_xfer | output | 1 | End-of-transfer flag |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_empty_evt | output | 1 | Transmit-empty event pulse |
| rx_full_evt | output | 1 | Receive-full event pulse |

## Verification
The bench writes new transmit data while an unread word is still held. A design that skips the receive-full gate would clock out the second word early. The bench then reads receive data to release the blocked word, and a design that does not treat the read as a request would hang. Single-channel mode is tested with force both clear and set. A design that clocks anyway would overwrite the receive register, and one that never completes would leave transmit-empty low. Further cases cover the transmit-only mode (receive-full must stay clear), receive-only mode with turbo (the word must start over a set receive-full with no receive event), a disabled channel, and word lengths of 4, 8 and 32. These catch wrong mode decodes and an off-by-one bit count.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

    localparam int CFG_W = 23;

    typedef enum logic [2:0] {
        SEL_CFG  = 3'd0,
        SEL_STAT = 3'd1,
        SEL_CTRL = 3'd2,
        SEL_TXD  = 3'd3,
        SEL_RXD  = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_DUPLEX  = 2'd0,
        MODE_RX_ONLY = 2'd1,
        MODE_TX_ONLY = 2'd2,
        MODE_BAD     = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic [1:0] spare_hi;   // 22:21
        logic       force_x;    // 20
        logic       turbo;      // 19
        logic [2:0] spare_mid;  // 18:16
        logic       rx_dma_en;  // 15
        logic       tx_dma_en;  // 14
        xfer_mode_e mode;       // 13:12
        logic [4:0] wl_m1;      // 11:7
        logic [6:0] spare_lo;   // 6:0
    } chan_cfg_t;

    typedef struct packed {
        logic eot;
        logic tx_empty;
        logic rx_full;
    } chan_stat_t;

    localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

    function automatic logic [5:0] word_len(input chan_cfg_t c);
        return {1'b0, c.wl_m1} + 6'd1;
    endfunction

endpackage

// File: rtl/spi_chan_gate.sv
module spi_chan_gate
    import spi_chan_pkg::*;
(
    input  logic       en,
    input  logic       rx_full,
    input  logic       tx_empty,
    input  xfer_mode_e mode,
    input  logic       turbo,
    input  logic       tx_dma_en,
    input  logic       rx_dma_en,
    input  logic       evt_q,
    output logic       may_start,
    output logic       tx_dma_req,
    output logic       rx_dma_req,
    output logic       tx_evt,
    output logic       rx_evt
);
    logic tx_side;
    logic rx_side;
    logic rx_block;
    logic tx_block;

    always_comb begin
        tx_side    = (mode != MODE_RX_ONLY);
        rx_side    = (mode != MODE_TX_ONLY);
        rx_block   = rx_full && rx_side && !turbo;
        tx_block   = tx_empty && tx_side;
        may_start  = en && !rx_block && !tx_block;
        tx_dma_req = en && tx_dma_en && tx_empty && tx_side;
        rx_dma_req = en && rx_dma_en && rx_full && rx_side;
        tx_evt     = evt_q && tx_empty && tx_side;
        rx_evt     = evt_q && rx_block;
    end

endmodule

// File: rtl/spi_chan_shifter.sv
module spi_chan_shifter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_len,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic              busy_q;
    logic              phase_q;
    logic [CNT_W-1:0]  left_q;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            left_q  <= '0;
            sh_q    <= '0;
            acc_q   <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            left_q  <= word_len;
            sh_q    <= tx_word << (FULL - word_len);
            acc_q   <= '0;
        end else if (busy_q) begin
            if (!phase_q) begin
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                sh_q    <= sh_q << 1;
                acc_q   <= {acc_q[DATA_W-2:0], miso};
                left_q  <= left_q - ONE;
                if (left_q == ONE) busy_q <= 1'b0;
            end
        end
    end

    assign busy    = busy_q;
    assign done    = busy_q && phase_q && (left_q == ONE);
    assign rx_word = {acc_q[DATA_W-2:0], miso};
    assign sclk    = busy_q && phase_q;
    assign mosi    = busy_q && sh_q[DATA_W-1];

endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
    import spi_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              single_chan,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              rx_full,
    output logic              tx_empty,
    output logic              end_of_xfer,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              tx_empty_evt,
    output logic              rx_full_evt
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    chan_cfg_t         cfg_q;
    chan_stat_t        stat_q;
    logic              en_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              pend_q;
    logic              evt_q;

    logic wr_cfg, wr_ctrl, wr_tx, rd_rx, trig;
    logic may_start, evaluate, exchange, start_sh, finish_now, complete, blocked;
    logic sh_busy, sh_done;
    logic [DATA_W-1:0] sh_rx;

    always_comb begin
        wr_cfg   = reg_wr && (reg_sel == SEL_CFG);
        wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
        wr_tx    = reg_wr && (reg_sel == SEL_TXD);
        rd_rx    = reg_rd && (reg_sel == SEL_RXD);
        trig     = wr_tx || rd_rx || (wr_ctrl && reg_wdata[0] && !en_q);
        evaluate = pend_q && !sh_busy;
        exchange = !single_chan || cfg_q.force_x;
        start_sh   = evaluate && may_start && exchange;
        finish_now = evaluate && may_start && !exchange;
        complete   = sh_done || finish_now;
        blocked    = evaluate && en_q && !may_start;
    end

    spi_chan_gate u_gate (
        .en        (en_q),
        .rx_full   (stat_q.rx_full),
        .tx_empty  (stat_q.tx_empty),
        .mode      (cfg_q.mode),
        .turbo     (cfg_q.turbo),
        .tx_dma_en (cfg_q.tx_dma_en),
        .rx_dma_en (cfg_q.rx_dma_en),
        .evt_q     (evt_q),
        .may_start (may_start),
        .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req),
        .tx_evt    (tx_empty_evt),
        .rx_evt    (rx_full_evt)
    );

    spi_chan_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start_sh),
        .word_len(CNT_W'(word_len(cfg_q))),
        .tx_word (tx_q),
        .miso    (miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_word (sh_rx),
        .sclk    (sclk),
        .mosi    (mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= chan_cfg_t'(CFG_RST);
            stat_q <= '{eot: 1'b0, tx_empty: 1'b1, rx_full: 1'b0};
            en_q   <= 1'b0;
            tx_q   <= '0;
            rx_q   <= '0;
            pend_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            pend_q <= trig || (pend_q && sh_busy);
            evt_q  <= complete || blocked;
            if (wr_cfg)  cfg_q <= chan_cfg_t'(reg_wdata[CFG_W-1:0]);
            if (wr_ctrl) en_q  <= reg_wdata[0];
            if (wr_tx) begin
                tx_q            <= reg_wdata;
                stat_q.tx_empty <= 1'b0;
            end else if (complete) begin
                tx_q            <= '0;
                stat_q.tx_empty <= 1'b1;
            end
            if (complete && (cfg_q.mode != MODE_TX_ONLY)) stat_q.rx_full <= 1'b1;
            else if (rd_rx)                               stat_q.rx_full <= 1'b0;
            if (complete) stat_q.eot <= 1'b1;
            if (sh_done)  rx_q <= sh_rx;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_CFG:  reg_rdata = DATA_W'(cfg_q);
            SEL_STAT: reg_rdata = DATA_W'(stat_q);
            SEL_CTRL: reg_rdata = DATA_W'(en_q);
            SEL_TXD:  reg_rdata = tx_q;
            SEL_RXD:  reg_rdata = rx_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign rx_full     = stat_q.rx_full;
    assign tx_empty    = stat_q.tx_empty;
    assign end_of_xfer = stat_q.eot;

endmodule

// File: rtl/spi_chan_engine_chk.sv
module spi_chan_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [2:0] reg_sel,
    input logic       sclk,
    input logic       rx_full,
    input logic       tx_empty,
    input logic       end_of_xfer,
    input logic       tx_dma_req,
    input logic       rx_dma_req,
    input logic       rx_full_evt
);
    a_r1_reset_flags: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_empty && !rx_full && !end_of_xfer));

    a_r2_sclk_one_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |=> !sclk);

    a_r7_tx_dma_needs_empty: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> tx_empty);

    a_r7_rx_dma_needs_full: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> rx_full);

    a_r8_rx_evt_needs_full: assert property (@(posedge clk) disable iff (rst)
        rx_full_evt |-> rx_full);

    a_r9_tx_write_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 3'd3) |=> !tx_empty);

    a_r10_eot_sticky: assert property (@(posedge clk) disable iff (rst)
        end_of_xfer |=> end_of_xfer);
endmodule

bind spi_chan_engine spi_chan_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .sclk       (sclk),
    .rx_full    (rx_full),
    .tx_empty   (tx_empty),
    .end_of_xfer(end_of_xfer),
    .tx_dma_req (tx_dma_req),
    .rx_dma_req (rx_dma_req),
    .rx_full_evt(rx_full_evt)
);

// File: tb/tb_spi_chan_engine.sv
module tb_spi_chan_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        single_chan = 1'b0;
    logic        miso = 1'b0;
    logic        sclk, mosi, rx_full, tx_empty, end_of_xfer;
    logic        tx_dma_req, rx_dma_req, tx_empty_evt, rx_full_evt;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    spi_chan_engine dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .single_chan(single_chan),
        .miso(miso), .sclk(sclk), .mosi(mosi), .rx_full(rx_full), .tx_empty(tx_empty),
        .end_of_xfer(end_of_xfer), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_empty_evt(tx_empty_evt), .rx_full_evt(rx_full_evt)
    );

    // behavioural reference model
    logic [22:0] m_cfg;
    logic [31:0] m_tx, m_rx, m_word, m_acc;
    bit m_en, m_rxf, m_txe, m_eot, m_pend, m_busy, m_ph, m_evt;
    int m_idx, m_wl;

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 23'h060000; m_tx = 0; m_rx = 0; m_word = 0; m_acc = 0;
            m_en = 0; m_rxf = 0; m_txe = 1; m_eot = 0; m_pend = 0;
            m_busy = 0; m_ph = 0; m_evt = 0; m_idx = 0; m_wl = 1;
        end else begin
            int  mode;
            bit  trig, evalq, okq, exch, done, comp, blk, was_busy;
            mode  = int'(m_cfg[13:12]);
            trig  = (reg_wr && reg_sel == 3) || (reg_rd && reg_sel == 4) ||
                    (reg_wr && reg_sel == 2 && reg_wdata[0] && !m_en);
            evalq = m_pend && !m_busy;
            okq   = m_en && !(m_rxf && mode != 2 && !m_cfg[19]) && !(m_txe && mode != 1);
            exch  = !single_chan || m_cfg[20];
            done  = m_busy && m_ph && (m_idx == m_wl - 1);
            comp  = done || (evalq && okq && !exch);
            blk   = evalq && m_en && !okq;
            was_busy = m_busy;
            if (m_busy) begin
                if (!m_ph) m_ph = 1;
                else begin
                    m_acc = (m_acc << 1) | 32'(miso);
                    m_ph = 0;
                    if (done) begin m_busy = 0; m_rx = m_acc; end
                    else m_idx++;
                end
            end
            if (evalq && okq && exch) begin
                m_busy = 1; m_ph = 0; m_idx = 0; m_acc = 0; m_word = m_tx;
                m_wl = int'(m_cfg[11:7]) + 1;
            end
            m_pend = trig || (m_pend && was_busy);
            m_evt  = comp || blk;
            if (reg_wr && reg_sel == 3) begin m_tx = reg_wdata; m_txe = 0; end
            else if (comp) begin m_tx = 0; m_txe = 1; end
            if (comp && mode != 2) m_rxf = 1;
            else if (reg_rd && reg_sel == 4) m_rxf = 0;
            if (comp) m_eot = 1;
            if (reg_wr && reg_sel == 2) m_en = reg_wdata[0];
            if (reg_wr && reg_sel == 0) m_cfg = reg_wdata[22:0];
        end
    end

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cycles, act, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (model_on) begin
            int  mode;
            logic [31:0] exp_rd;
            mode = int'(m_cfg[13:12]);
            case (reg_sel)
                3'd0: exp_rd = {9'd0, m_cfg};
                3'd1: exp_rd = {29'd0, m_eot, m_txe, m_rxf};
                3'd2: exp_rd = {31'd0, m_en};
                3'd3: exp_rd = m_tx;
                3'd4: exp_rd = m_rx;
                default: exp_rd = 0;
            endcase
            cmp("R2", "sclk", 32'(sclk), 32'(m_busy && m_ph));
            cmp("R2", "mosi", 32'(mosi), 32'(m_busy && m_word[m_wl-1-m_idx]));
            cmp("R6", "flags", {29'd0, end_of_xfer, tx_empty, rx_full}, {29'd0, m_eot, m_txe, m_rxf});
            cmp("R7", "tx_dma", 32'(tx_dma_req), 32'(m_en && m_cfg[14] && m_txe && mode != 1));
            cmp("R7", "rx_dma", 32'(rx_dma_req), 32'(m_en && m_cfg[15] && m_rxf && mode != 2));
            cmp("R8", "tx_evt", 32'(tx_empty_evt), 32'(m_evt && m_txe && mode != 1));
            cmp("R8", "rx_evt", 32'(rx_full_evt), 32'(m_evt && m_rxf && mode != 2 && !m_cfg[19]));
            cmp("R1", "rdata", reg_rdata, exp_rd);
        end
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_strobe(logic [2:0] s);
        reg_sel = s; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic peek(logic [2:0] s, logic [31:0] exp, string tag);
        reg_sel = s;
        #1;
        cmp(tag, "register read", reg_rdata, exp);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        model_on = 1'b1;
        tick();
        // R1: reset values
        peek(3'd0, 32'h0006_0000, "R1");
        peek(3'd1, 32'd2, "R1");
        peek(3'd2, 32'd0, "R1");
        // R1: high bits dropped; wl 8, duplex, tx dma enabled
        wr(3'd0, 32'hFF80_4380);
        peek(3'd0, 32'h0000_4380, "R1");
        // R9/R8: enabling requests a decision; blocked by tx_empty -> event
        wr(3'd2, 32'd1);
        tick();
        cmp("R8", "tx event after blocked start", 32'(tx_empty_evt), 32'd1);
        cmp("R7", "tx dma when enabled and empty", 32'(tx_dma_req), 32'd1);
        // R2/R6: 8-bit word, miso held high
        miso = 1'b1;
        wr(3'd3, 32'h0000_00A5);
        tick(20);
        peek(3'd1, 32'd7, "R6");
        peek(3'd3, 32'd0, "R6");
        peek(3'd4, 32'h0000_00FF, "R2");
        // R4: receive-full blocks the next word in duplex without turbo
        miso = 1'b0;
        wr(3'd3, 32'h0000_003C);
        tick(24);
        peek(3'd1, 32'd5, "R4");
        peek(3'd3, 32'h0000_003C, "R4");
        // R9: reading receive data releases it
        rd_strobe(3'd4);
        tick(20);
        peek(3'd1, 32'd7, "R9");
        peek(3'd4, 32'd0, "R9");
        // R5: single-channel without force completes with no clocking
        single_chan = 1'b1;
        miso = 1'b1;
        rd_strobe(3'd4);
        wr(3'd3, 32'h0000_0055);
        tick();
        peek(3'd1, 32'd7, "R5");
        peek(3'd4, 32'd0, "R5");
        // R5: force bit set -> word is clocked
        wr(3'd0, 32'h0010_4380);
        rd_strobe(3'd4);
        wr(3'd3, 32'h0000_000F);
        tick(20);
        peek(3'd4, 32'h0000_00FF, "R5");
        single_chan = 1'b0;
        // R3/R6: transmit only leaves receive-full clear
        wr(3'd0, 32'h0000_6380);
        rd_strobe(3'd4);
        wr(3'd3, 32'h0000_0081);
        tick(20);
        peek(3'd1, 32'd6, "R3");
        cmp("R7", "tx dma in transmit-only", 32'(tx_dma_req), 32'd1);
        // R3/R2: receive only, wl 4, rx dma enabled; starts despite tx_empty
        wr(3'd0, 32'h0000_9180);
        rd_strobe(3'd4);
        tick(12);
        peek(3'd4, 32'h0000_000F, "R2");
        cmp("R7", "rx dma in receive-only", 32'(rx_dma_req), 32'd1);
        // R4: turbo lets a word start over a set receive-full
        miso = 1'b0;
        wr(3'd0, 32'h0008_9180);
        wr(3'd2, 32'd0);
        wr(3'd2, 32'd1);
        tick(12);
        peek(3'd4, 32'd0, "R4");
        // R10: disabled channel, duplex, wl 32
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h0000_0F80);
        wr(3'd3, 32'h1234_5678);
        tick(10);
        peek(3'd1, 32'd5, "R10");
        cmp("R10", "no tx event while disabled", 32'(tx_empty_evt), 32'd0);
        // R2: 32-bit word after enabling and freeing receive
        miso = 1'b1;
        wr(3'd2, 32'd1);
        tick(4);
        peek(3'd1, 32'd5, "R4");
        rd_strobe(3'd4);
        tick(70);
        peek(3'd4, 32'hFFFF_FFFF, "R2");
        peek(3'd1, 32'd7, "R6");
        tick(2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule